// File: doc/BRIEF.md
# Asynchronous Wake-up Interrupt Controller

This block takes over interrupt watching while the system clock is stopped in deep sleep. Just before the clock is gated, the clocked interrupt logic primes it with a single strobe that carries the current enable mask. That strobe also arms the block. From then on, any request line whose mask bit is set, or the non-maskable request, raises the wake request at once, with no clock edge needed. A request that is only a brief pulse is also held in a pending bit.

After the clock restarts, the clocked domain reads the pending vector through two-flop synchronizers. It then acknowledges the wake with a disarm strobe. The disarm drops the wake request, and the pending bits clear on the next clock edge. The block has no priority scheme, no vector fetch and no register interface. It keeps only the mask snapshot, the armed flag and the pending bits.

Top module: `awic_wake`

## Requirements
- R1: While armed, a high level on request line i with mask bit i equal to 1 drives `wake_o` to 1 in the same time step, with no clock edge in between.
- R2: A request line whose mask bit is 0 never raises `wake_o` and never sets its bit of `pend_o`.
- R3: While armed, a high `nmi_i` raises `wake_o` whatever the mask, and sets `nmi_pend_o`.
- R4: While disarmed, request lines and `nmi_i` are ignored: `wake_o` stays 0 and no pending bit is set.
- R5: A `prime_i` strobe sampled while disarmed copies `mask_i` into the mask snapshot and arms the block from that clock edge on. A `prime_i` strobe sampled while armed is ignored.
- R6: When `prime_i` and `disarm_i` are sampled at the same edge, disarm wins: the block ends up disarmed and the snapshot is unchanged.
- R7: Once `wake_o` is 1 it stays 1 after the request goes away, until a `disarm_i` strobe is sampled. `wake_o` drops at that edge.
- R8: A pending bit is set by any qualifying request pulse, however short. Pending bits collect over several pulses. They are cleared by the first clock edge at which the block is already disarmed.
- R9: `wake_sync_o`, `pend_o` and `nmi_pend_o` are the raw wake and pending values delayed through a two-flop synchronizer.
- R10: While `rst_ni` is low, and after it is released, the block is disarmed with a zero mask and all outputs at 0. Reset is applied at once and released through a two-flop reset synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the domain that primes and acknowledges the block |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prime_i | input | 1 | Priming strobe: captures `mask_i` and arms the block |
| disarm_i | input | 1 | Acknowledge strobe: disarms the block and drops the wake request |
| mask_i | input | NUM_IRQ | Enable mask captured on priming (1 = line may wake) |
| irq_i | input | NUM_IRQ | Interrupt request lines, active high |
| nmi_i | input | 1 | Non-maskable request, active high |
| wake_o | output | 1 | Wake request, combinational and with no clock needed |
| wake_sync_o | output | 1 | `wake_o` after the two-flop synchronizer |
| pend_o | output | NUM_IRQ | Synchronized pending vector, one bit per request line |
| nmi_pend_o | output | 1 | Synchronized pending flag of the non-maskable request |

## Verification
Two things can land at the same clock edge: priming and acknowledging. A prime meant to arm the block can meet a disarm, and a request can arrive while the armed state is changing. The bench drives `prime_i` and `disarm_i` high together on a disarmed block. It then fires the non-maskable request and a request on an enabled line. The block is judged correct only if `wake_o` and `pend_o` stay 0, which shows that disarm took priority and that no mask was captured. A second case holds a request high before priming, so the first edge that arms the block must also raise the wake request.

// File: rtl/awic_pkg.sv
`timescale 1ns/1ps
package awic_pkg;
  // Default number of request lines watched during deep sleep
  localparam int unsigned AWIC_LINES_DEF  = 32;
  // Flops in each clock-domain crossing chain
  localparam int unsigned AWIC_SYNC_DEPTH = 2;

  // Control state kept between priming and acknowledge
  typedef enum logic {
    AWIC_IDLE  = 1'b0,
    AWIC_ARMED = 1'b1
  } awic_state_e;
endpackage

// File: rtl/awic_rst_sync.sv
`timescale 1ns/1ps
module awic_rst_sync #(
  parameter int unsigned STAGES = awic_pkg::AWIC_SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/awic_ctrl.sv
`timescale 1ns/1ps
module awic_ctrl
  import awic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = AWIC_LINES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prime_i,
  input  logic               disarm_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  output logic               armed_o,
  output logic [NUM_IRQ-1:0] mask_o
);
  awic_state_e       state_q, state_d;
  logic [NUM_IRQ-1:0] mask_q;
  logic               mask_en;

  // Next state: acknowledge outranks priming; priming only from idle
  always_comb begin
    state_d = state_q;
    mask_en = 1'b0;
    if (disarm_i) begin
      state_d = AWIC_IDLE;
    end else if (prime_i && (state_q == AWIC_IDLE)) begin
      state_d = AWIC_ARMED;
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= AWIC_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_i;
  end

  assign armed_o = (state_q == AWIC_ARMED);
  assign mask_o  = mask_q;

  // R5
  mask_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> $stable(mask_o));
  // R5
  prime_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && prime_i && !disarm_i) |=> (armed_o && mask_o == $past(mask_i)));
  // R6
  disarm_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_i |=> (!armed_o && $stable(mask_o)));
endmodule

// File: rtl/awic_pend.sv
`timescale 1ns/1ps
module awic_pend #(
  parameter int unsigned NUM_IRQ = awic_pkg::AWIC_LINES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               armed_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               nmi_pend_o
);
  localparam int unsigned SRC = NUM_IRQ + 1;

  logic [SRC-1:0] set_w;
  logic [SRC-1:0] hold_w;

  // Asynchronous set terms: top bit is the non-maskable source
  always_comb begin
    set_w = {armed_i & nmi_i, {NUM_IRQ{armed_i}} & mask_i & irq_i};
  end

  // One capture flop per source: set without a clock, cleared by a clock edge once disarmed
  for (genvar g = 0; g < SRC; g++) begin : g_src
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni or posedge set_w[g]) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_w[g]) bit_q <= 1'b1;
      else if (!armed_i) bit_q <= 1'b0;
    end
    assign hold_w[g] = bit_q;
  end

  assign pend_o     = hold_w[NUM_IRQ-1:0];
  assign nmi_pend_o = hold_w[NUM_IRQ];

  // R2
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> ((pend_o & ~mask_i) == '0));
  // R8
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(armed_i) |-> ((hold_w & $past(hold_w)) == $past(hold_w)));
endmodule

// File: rtl/awic_sync.sv
`timescale 1ns/1ps
module awic_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = awic_pkg::AWIC_SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = din_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_d;
    end
  end

  assign dout_o = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    // R9
    sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dout_o == $past(din_i, 2));
  end
endmodule

// File: rtl/awic_wake.sv
`timescale 1ns/1ps
module awic_wake
  import awic_pkg::*;
#(
  parameter int unsigned NUM_IRQ = AWIC_LINES_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prime_i,
  input  logic               disarm_i,
  input  logic [NUM_IRQ-1:0] mask_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               nmi_i,
  output logic               wake_o,
  output logic               wake_sync_o,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic               nmi_pend_o
);
  localparam int unsigned XW = NUM_IRQ + 2;

  logic               rst_n;
  logic               armed;
  logic [NUM_IRQ-1:0] mask_snap;
  logic [NUM_IRQ-1:0] pend_raw;
  logic               nmi_raw;
  logic [XW-1:0]      xing_in;
  logic [XW-1:0]      xing_out;

  awic_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  awic_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .prime_i  (prime_i),
    .disarm_i (disarm_i),
    .mask_i   (mask_i),
    .armed_o  (armed),
    .mask_o   (mask_snap)
  );

  awic_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .armed_i    (armed),
    .mask_i     (mask_snap),
    .irq_i      (irq_i),
    .nmi_i      (nmi_i),
    .pend_o     (pend_raw),
    .nmi_pend_o (nmi_raw)
  );

  // Wake path has no flop: armed flag gates the held capture bits
  assign wake_o  = armed & ((|pend_raw) | nmi_raw);
  assign xing_in = {nmi_raw, pend_raw, wake_o};

  awic_sync #(.WIDTH(XW)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .din_i  (xing_in),
    .dout_o (xing_out)
  );

  assign wake_sync_o = xing_out[0];
  assign pend_o      = xing_out[NUM_IRQ:1];
  assign nmi_pend_o  = xing_out[XW-1];

  // R1
  unmasked_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed && ((irq_i & mask_snap) != '0)) |-> wake_o);
  // R3
  nmi_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed && nmi_i) |-> wake_o);
  // R4
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !armed |-> !wake_o);
  // R7
  wake_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wake_o && !disarm_i) |=> wake_o);
  // R7
  ack_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    disarm_i |=> !wake_o);
endmodule

// File: tb/awic_wake_tb.sv
`timescale 1ns/1ps
module awic_wake_tb;
  localparam int N = 32;
  localparam int NV = 8;
  // {nmi, mask, irq pulse}
  localparam logic [2*N:0] VEC [NV] = '{
    {1'b0, 32'hFFFF_FFFF, 32'h0000_0001},
    {1'b0, 32'h0000_00F0, 32'h0000_000F},
    {1'b0, 32'h8000_0000, 32'h8000_0000},
    {1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
    {1'b0, 32'hA5A5_0000, 32'hFF00_FF00},
    {1'b0, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 32'h0F0F_0F0F, 32'h0101_0101},
    {1'b0, 32'hFFFF_0000, 32'h0000_FFFF}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         prime, disarm, nmi;
  logic [N-1:0] mask, irq;
  logic         wake, wake_s, nmi_p;
  logic [N-1:0] pend;
  int           n_chk = 0;
  int           n_fail = 0;

  always #2 clk = ~clk;

  awic_wake #(.NUM_IRQ(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prime_i(prime), .disarm_i(disarm),
    .mask_i(mask), .irq_i(irq), .nmi_i(nmi),
    .wake_o(wake), .wake_sync_o(wake_s), .pend_o(pend), .nmi_pend_o(nmi_p)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_prime(input logic [N-1:0] m);
    @(negedge clk); prime = 1'b1; mask = m;
    @(negedge clk); prime = 1'b0;
  endtask

  task automatic do_disarm();
    @(negedge clk); disarm = 1'b1;
    @(negedge clk); disarm = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] p, input logic n);
    #0.4 irq = p; nmi = n;
    #0.6 irq = '0; nmi = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prime = 1'b0; disarm = 1'b0; nmi = 1'b0; mask = '0; irq = '0;
    edges(3);
    // R10 reset state
    chk("R10 wake", {63'd0, wake}, 64'd0);
    chk("R10 pend", {31'd0, nmi_p, pend}, 64'd0);
    rst_n = 1'b1;
    edges(4);
    chk("R10 sync wake", {63'd0, wake_s}, 64'd0);

    // R4: disarmed block ignores requests and nmi
    @(negedge clk); pulse('1, 1'b1);
    chk("R4 wake", {63'd0, wake}, 64'd0);
    edges(4);
    chk("R4 pend", {31'd0, nmi_p, pend}, 64'd0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      logic         vn;
      logic [N-1:0] vm, vi, ep;
      logic         ew;
      {vn, vm, vi} = VEC[v];
      ep = vm & vi;
      ew = (ep != '0) | vn;
      do_prime(vm);
      #0.4 irq = vi; nmi = vn;
      #0.4 chk("R1 R2 R3 async wake", {63'd0, wake}, {63'd0, ew});
      #0.2 irq = '0; nmi = 1'b0;
      edges(3);
      chk("R7 wake held", {63'd0, wake}, {63'd0, ew});
      chk("R9 wake sync", {63'd0, wake_s}, {63'd0, ew});
      chk("R8 R2 pend", {32'd0, pend}, {32'd0, ep});
      chk("R3 nmi pend", {63'd0, nmi_p}, {63'd0, vn});
      do_disarm();
      chk("R7 ack drop", {63'd0, wake}, 64'd0);
      edges(4);
      chk("R8 pend cleared", {31'd0, nmi_p, pend}, 64'd0);
    end

    // R8: short pulses on separate lines collect
    do_prime(32'h0000_0088);
    @(negedge clk); pulse(32'h0000_0008, 1'b0);
    @(negedge clk); pulse(32'h0000_0080, 1'b0);
    edges(3);
    chk("R8 accumulate", {32'd0, pend}, {32'd0, 32'h0000_0088});
    do_disarm(); edges(4);

    // R5: prime while armed is ignored
    do_prime(32'h0000_0001);
    do_prime(32'h0000_0002);
    @(negedge clk); pulse(32'h0000_0002, 1'b0);
    chk("R5 reprime ignored", {63'd0, wake}, 64'd0);
    @(negedge clk); pulse(32'h0000_0001, 1'b0);
    chk("R5 first mask kept", {63'd0, wake}, 64'd1);
    do_disarm(); edges(4);

    // R6: prime and disarm together on a disarmed block
    @(negedge clk); prime = 1'b1; disarm = 1'b1; mask = '1;
    @(negedge clk); prime = 1'b0; disarm = 1'b0;
    pulse(32'h0000_0010, 1'b1);
    chk("R6 collision wake", {63'd0, wake}, 64'd0);
    edges(4);
    chk("R6 collision pend", {31'd0, nmi_p, pend}, 64'd0);

    // R1: level held before priming wakes at the arming edge
    @(negedge clk); irq = 32'h0000_0020;
    chk("R4 level disarmed", {63'd0, wake}, 64'd0);
    do_prime(32'h0000_0020);
    chk("R1 level at arm", {63'd0, wake}, 64'd1);
    irq = '0;
    do_disarm(); edges(4);

    // R10: reset mid-wake clears everything
    do_prime('1);
    @(negedge clk); pulse(32'h0000_0004, 1'b0);
    edges(3);
    rst_n = 1'b0;
    #0.5 chk("R10 async reset", {62'd0, wake, wake_s}, 64'd0);
    chk("R10 reset pend", {32'd0, pend}, 64'd0);
    rst_n = 1'b1;
    edges(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule